// File: doc/BRIEF.md
# Checkpointed Register File with Gated Store Queue

This block holds the speculative architectural state of one translated code region. A small working register file takes every register write. A matching shadow file keeps the last committed copy. Stores never go straight to memory. They wait in a gated queue until the region's outcome is known. A single commit strobe publishes the whole region: the shadow file takes the working values, and the queued stores are released to memory. A single rollback strobe undoes the whole region: the working file is reloaded from the shadow, and all unreleased stores are dropped. Faults and mispredicted speculative branches both use the same rollback strobe.

Released stores leave through a valid/ready memory write port. They go out oldest first, one per accepted handshake. New stores are held off until the drain completes. A load address can be looked up against the pending stores, and the youngest matching entry is forwarded.

Top module: `spec_state_buffer`

## Requirements
- R1: After reset, every working register reads 0, `full` is 0, `mem_valid` is 0, `st_ready` is 1 and `ld_hit` is 0.
- R2: A register write with `wr_en` high changes only the working copy. It is visible on `rd_data` (combinational read of `rd_idx`) from the next cycle on. The shadow copy is left unchanged unless a commit is active.
- R3: A commit (`commit` high, `rollback` low) copies every working register into its shadow. A register write in the same cycle is part of the copy.
- R4: A rollback reloads every working register from its shadow. A register write in the same cycle is discarded.
- R5: When `commit` and `rollback` are high together, the rollback is performed and the shadow file is not updated.
- R6: Accepted stores do not appear on the memory port before a commit. `mem_valid` stays 0 while stores are only pending.
- R7: After a commit, the queued stores appear on the memory port in the order they were accepted, one per cycle in which `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the presented address, data and byte mask (`mem_mask` bit k enables byte k, bits 8k+7..8k) stay unchanged.
- R8: While committed stores are draining, `st_ready` is 0.
- R9: A rollback while no drain is in progress discards every pending store. None of them ever reaches the memory port, and none of them forwards afterwards.
- R10: With DEPTH stores pending, `full` is 1 and `st_ready` is 0. A store held on `st_valid` is then stalled rather than dropped, and it is accepted once space returns.
- R11: `ld_hit` is 1 when `ld_addr` equals the address of any pending store. `ld_data` and `ld_mask` then come from the youngest such store. With no match, `ld_hit` is 0.
- R12: A store accepted in the same cycle as a commit is released with that commit. A store presented in the same cycle as a rollback is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | $clog2(NREGS) | Register write index |
| wr_data | input | DW | Register write data |
| rd_idx | input | $clog2(NREGS) | Register read index |
| rd_data | output | DW | Working register read data |
| commit | input | 1 | Commit the region |
| rollback | input | 1 | Roll the region back (wins over commit) |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_mask | input | DW/8 | Store byte enables |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | A pending store matches the lookup |
| ld_data | output | DW | Data of youngest matching store |
| ld_mask | output | DW/8 | Byte enables of youngest matching store |
| mem_valid | output | 1 | Released store presented to memory |
| mem_ready | input | 1 | Memory accepts the presented store |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |
| mem_mask | output | DW/8 | Memory write byte enables |
| full | output | 1 | Store queue holds DEPTH entries |

## Verification
The register checkpoint is tried with four patterns:
- a plain write then rollback, which shows that the shadow was not touched;
- a write then commit then overwrite then rollback, which shows what the commit captured;
- a write in the same cycle as each strobe, which separates "write included" from "write discarded";
- both strobes together, which separates rollback priority from a commit that also happened.

The store side is tried with three patterns:
- repeated addresses, which exposes oldest-versus-youngest forwarding;
- a drain against a memory that stalls two cycles in three, which exposes reordering and unstable data;
- a full queue with a fifth store held waiting, which tells a stall apart from a silent drop.

Stores presented alongside a commit or a rollback show which side of the strobe each store falls on.

// File: rtl/spec_pkg.sv
package spec_pkg;
    // Store queue operating mode: open accepts new speculative stores,
    // drain releases committed stores to memory.
    typedef enum logic {
        Q_OPEN  = 1'b0,
        Q_DRAIN = 1'b1
    } qmode_e;
endpackage

// File: rtl/ckpt_regfile.sv
module ckpt_regfile #(
    parameter int NREGS = 8,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     commit,
    input  logic                     rollback,
    input  logic [$clog2(NREGS)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data
);
    typedef struct packed {
        logic [NREGS-1:0][DW-1:0] work;
        logic [NREGS-1:0][DW-1:0] shadow;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        logic [NREGS-1:0][DW-1:0] upd;
        rf_d = rf_q;
        upd  = rf_q.work;
        if (wr_en) upd[wr_idx] = wr_data;
        if (rollback) begin
            rf_d.work = rf_q.shadow;
        end else begin
            rf_d.work = upd;
            if (commit) rf_d.shadow = upd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign rd_data = rf_q.work[rd_idx];

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit || rollback) |=> $stable(rf_q.shadow)); // R2
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rollback) |=> (rf_q.shadow == rf_q.work)); // R3
    AST_ROLLBACK_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> (rf_q.work == $past(rf_q.shadow))); // R4
    AST_ROLLBACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && commit) |=> (rf_q.work == rf_q.shadow)); // R5
endmodule

// File: rtl/store_gate_queue.sv
module store_gate_queue
    import spec_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic            rollback,
    input  logic            st_valid,
    output logic            st_ready,
    input  logic [AW-1:0]   st_addr,
    input  logic [DW-1:0]   st_data,
    input  logic [DW/8-1:0] st_mask,
    input  logic [AW-1:0]   ld_addr,
    output logic            ld_hit,
    output logic [DW-1:0]   ld_data,
    output logic [DW/8-1:0] ld_mask,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_data,
    output logic [DW/8-1:0] mem_mask,
    output logic            full
);
    localparam int MW = DW / 8;
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [DEPTH-1:0][MW-1:0] mask;
        logic [PW-1:0]            head;
        logic [CW-1:0]            count;
        qmode_e                   mode;
    } sq_t;

    sq_t sq_d, sq_q;

    logic          push, pop;
    logic [PW-1:0] tail;

    assign full      = (sq_q.count == CW'(DEPTH));
    assign st_ready  = (sq_q.mode == Q_OPEN) && !full;
    assign mem_valid = (sq_q.mode == Q_DRAIN) && (sq_q.count != '0);
    assign mem_addr  = sq_q.addr[sq_q.head];
    assign mem_data  = sq_q.data[sq_q.head];
    assign mem_mask  = sq_q.mask[sq_q.head];
    assign push      = st_valid && st_ready;
    assign pop       = mem_valid && mem_ready;
    assign tail      = sq_q.head + sq_q.count[PW-1:0];

    always_comb begin
        sq_d = sq_q;
        if (rollback && (sq_q.mode == Q_OPEN)) begin
            sq_d.count = '0;
            sq_d.mode  = Q_OPEN;
        end else begin
            if (push) begin
                sq_d.addr[tail] = st_addr;
                sq_d.data[tail] = st_data;
                sq_d.mask[tail] = st_mask;
            end
            if (pop) sq_d.head = sq_q.head + PW'(1);
            sq_d.count = sq_q.count + CW'(push) - CW'(pop);
            if (((sq_q.mode == Q_DRAIN) || (commit && !rollback)) && (sq_d.count != '0))
                sq_d.mode = Q_DRAIN;
            else
                sq_d.mode = Q_OPEN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    // Forwarding: scan oldest to youngest, the last match wins.
    always_comb begin
        ld_hit  = 1'b0;
        ld_data = '0;
        ld_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CW'(i) < sq_q.count) && (sq_q.addr[sq_q.head + PW'(i)] == ld_addr)) begin
                ld_hit  = 1'b1;
                ld_data = sq_q.data[sq_q.head + PW'(i)];
                ld_mask = sq_q.mask[sq_q.head + PW'(i)];
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !st_ready); // R10
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_mask))); // R7
    AST_DRAIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !st_ready); // R8
    AST_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && !mem_valid) |=> (sq_q.count == '0)); // R9
    AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid && !commit) |=> !mem_valid); // R6
endmodule

// File: rtl/spec_state_buffer.sv
module spec_state_buffer #(
    parameter int NREGS = 8,
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [$clog2(NREGS)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data,
    input  logic                     commit,
    input  logic                     rollback,
    input  logic                     st_valid,
    output logic                     st_ready,
    input  logic [AW-1:0]            st_addr,
    input  logic [DW-1:0]            st_data,
    input  logic [DW/8-1:0]          st_mask,
    input  logic [AW-1:0]            ld_addr,
    output logic                     ld_hit,
    output logic [DW-1:0]            ld_data,
    output logic [DW/8-1:0]          ld_mask,
    output logic                     mem_valid,
    input  logic                     mem_ready,
    output logic [AW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_data,
    output logic [DW/8-1:0]          mem_mask,
    output logic                     full
);
    ckpt_regfile #(.NREGS(NREGS), .DW(DW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .commit   (commit),
        .rollback (rollback),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

    store_gate_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_stq (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .rollback  (rollback),
        .st_valid  (st_valid),
        .st_ready  (st_ready),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_mask   (st_mask),
        .ld_addr   (ld_addr),
        .ld_hit    (ld_hit),
        .ld_data   (ld_data),
        .ld_mask   (ld_mask),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_mask  (mem_mask),
        .full      (full)
    );
endmodule

// File: tb/test_spec_state_buffer.sv
module test_spec_state_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int NREGS = 8;
    localparam int DW    = 32;
    localparam int AW    = 16;
    localparam int DEPTH = 4;
    localparam int MW    = DW / 8;
    localparam int IW    = $clog2(NREGS);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [MW-1:0] mask;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [DW-1:0] rd_data;
    logic commit = 1'b0, rollback = 1'b0;
    logic st_valid = 1'b0;
    logic st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [MW-1:0] st_mask = '0;
    logic [AW-1:0] ld_addr = '0;
    logic ld_hit;
    logic [DW-1:0] ld_data;
    logic [MW-1:0] ld_mask;
    logic mem_valid;
    logic mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic [MW-1:0] mem_mask;
    logic full;

    int checks = 0;
    int errors = 0;
    bit slow = 1'b0;
    int rcyc = 0;
    item_t pend[$];
    item_t expq[$];

    spec_state_buffer #(.NREGS(NREGS), .DW(DW), .AW(AW), .DEPTH(DEPTH)) i_spec_state_buffer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .commit(commit), .rollback(rollback),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .st_mask(st_mask), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .ld_mask(ld_mask), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_mask(mem_mask), .full(full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_reg(input int idx, input logic [DW-1:0] exp, input string req);
        rd_idx = IW'(idx);
        #1;
        chk(req, 64'(rd_data), 64'(exp));
    endtask

    task automatic wr_reg(input int idx, input logic [DW-1:0] val);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = val;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_commit();
        commit = 1'b1;
        step();
        commit = 1'b0;
        foreach (pend[k]) expq.push_back(pend[k]);
        pend.delete();
    endtask

    task automatic do_rollback();
        rollback = 1'b1;
        step();
        rollback = 1'b0;
        pend.delete();
    endtask

    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [MW-1:0] m);
        st_valid = 1'b1; st_addr = a; st_data = d; st_mask = m;
        while (!st_ready) step();
        step();
        st_valid = 1'b0;
        pend.push_back('{addr: a, data: d, mask: m});
    endtask

    task automatic wait_drain(input string req);
        while (mem_valid || expq.size() != 0) step();
        chk(req, 64'(expq.size()), 64'd0);
    endtask

    // Memory ready pattern: stalls two cycles out of three in slow mode.
    always @(posedge clk) begin
        #1;
        rcyc++;
        mem_ready = slow ? (rcyc % 3 == 0) : 1'b1;
    end

    // Scoreboard monitor.
    logic pv = 1'b0, pr = 1'b0;
    logic [AW-1:0] pa = '0;
    logic [DW-1:0] pd = '0;
    logic [MW-1:0] pm = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pv && !pr)
                chk("R7 hold", {mem_valid, 7'd0, mem_addr, mem_data, mem_mask},
                               {1'b1, 7'd0, pa, pd, pm});
            if (mem_valid && mem_ready) begin
                if (expq.size() == 0) begin
                    chk("R6/R9 unexpected memory write", 64'(mem_addr), 64'hFFFF_FFFF);
                end else begin
                    item_t e;
                    e = expq.pop_front();
                    chk("R7 order", {8'd0, mem_addr, mem_data, mem_mask},
                                    {8'd0, e.addr, e.data, e.mask});
                end
            end
            pv = mem_valid; pr = mem_ready; pa = mem_addr; pd = mem_data; pm = mem_mask;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk_reg(0, '0, "R1");
        chk_reg(5, '0, "R1");
        chk("R1 full", 64'(full), 0);
        chk("R1 mem_valid", 64'(mem_valid), 0);
        chk("R1 st_ready", 64'(st_ready), 1);
        chk("R1 ld_hit", 64'(ld_hit), 0);

        // R2 working write, shadow untouched
        wr_reg(1, 32'h11);
        wr_reg(2, 32'h22);
        chk_reg(1, 32'h11, "R2");
        chk_reg(2, 32'h22, "R2");
        do_rollback();
        chk_reg(1, '0, "R2/R4 rollback");

        // R3 commit then overwrite then rollback
        wr_reg(3, 32'h33);
        do_commit();
        wr_reg(3, 32'h44);
        chk_reg(3, 32'h44, "R2");
        do_rollback();
        chk_reg(3, 32'h33, "R3/R4");

        // R4 write in rollback cycle discarded
        wr_en = 1'b1; wr_idx = 3'd5; wr_data = 32'h55; rollback = 1'b1;
        step();
        wr_en = 1'b0; rollback = 1'b0;
        chk_reg(5, '0, "R4 same-cycle write");

        // R3 write in commit cycle captured
        wr_en = 1'b1; wr_idx = 3'd6; wr_data = 32'h66; commit = 1'b1;
        step();
        wr_en = 1'b0; commit = 1'b0;
        wr_reg(6, 32'h1);
        do_rollback();
        chk_reg(6, 32'h66, "R3 same-cycle write");

        // R5 rollback wins over commit
        wr_reg(3, 32'h77);
        commit = 1'b1; rollback = 1'b1;
        step();
        commit = 1'b0; rollback = 1'b0;
        chk_reg(3, 32'h33, "R5");
        wr_reg(3, 32'h88);
        do_rollback();
        chk_reg(3, 32'h33, "R5 shadow kept");

        // R6 / R11 stores gated, forwarding youngest
        store(16'h0010, 32'hA1A1_0001, 4'hF);
        store(16'h0020, 32'hB2B2_0002, 4'h3);
        store(16'h0010, 32'hC3C3_0003, 4'hC);
        step(); step();
        chk("R6 gated", 64'(mem_valid), 0);
        ld_addr = 16'h0010;
        #1;
        chk("R11 hit", 64'(ld_hit), 1);
        chk("R11 youngest data", 64'(ld_data), 64'hC3C3_0003);
        chk("R11 youngest mask", 64'(ld_mask), 64'hC);
        ld_addr = 16'h0030;
        #1;
        chk("R11 miss", 64'(ld_hit), 0);

        // R7 / R8 drain against a stalling memory
        slow = 1'b1;
        do_commit();
        chk("R7 drain starts", 64'(mem_valid), 1);
        chk("R8 st_ready low", 64'(st_ready), 0);
        wait_drain("R7 all drained");
        slow = 1'b0;

        // R9 rollback discards pending stores
        store(16'h0040, 32'h4444, 4'hF);
        store(16'h0050, 32'h5555, 4'hF);
        do_rollback();
        ld_addr = 16'h0040;
        #1;
        chk("R9 no forward", 64'(ld_hit), 0);
        repeat (4) step();
        chk("R9 no write", 64'(mem_valid), 0);

        // R10 full, held store not dropped
        for (int i = 0; i < DEPTH; i++) store(AW'(16'h0100 + i), DW'(32'h1000 + i), 4'hF);
        chk("R10 full", 64'(full), 1);
        chk("R10 st_ready", 64'(st_ready), 0);
        st_valid = 1'b1; st_addr = 16'h0200; st_data = 32'hDEAD_0200; st_mask = 4'h5;
        repeat (3) step();
        chk("R10 stalled", 64'(st_ready), 0);
        do_commit();
        while (!st_ready) step();
        step();
        st_valid = 1'b0;
        pend.push_back('{addr: 16'h0200, data: 32'hDEAD_0200, mask: 4'h5});
        chk("R10 held store pending", 64'(pend.size()), 1);
        do_commit();
        wait_drain("R10 held store drained");

        // R12 store alongside commit / rollback
        st_valid = 1'b1; st_addr = 16'h0060; st_data = 32'h6060; st_mask = 4'hF; commit = 1'b1;
        #1;
        chk("R12 ready at commit", 64'(st_ready), 1);
        step();
        st_valid = 1'b0; commit = 1'b0;
        expq.push_back('{addr: 16'h0060, data: 32'h6060, mask: 4'hF});
        wait_drain("R12 store with commit");
        st_valid = 1'b1; st_addr = 16'h0070; st_data = 32'h7070; st_mask = 4'hF; rollback = 1'b1;
        step();
        st_valid = 1'b0; rollback = 1'b0;
        ld_addr = 16'h0070;
        #1;
        chk("R12 store with rollback dropped", 64'(ld_hit), 0);
        repeat (4) step();
        chk("R12 no write", 64'(mem_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule